// File: doc/BRIEF.md
# Limit-Match Counter Timer

This block is a word-addressed counter/timer for system use. A counter advances by one unit each time the single-cycle `tick_en` input is high, which stands in for a fixed 500 ns period. The count is held in bits 30..9 of a 32-bit word, so bits 8..0 always read as zero. The counter is compared against a programmable limit. When the count reaches a nonzero limit, the block sets a sticky reached flag and raises a level interrupt. The count returns to zero on the next tick.

Software reads the limit register to acknowledge the event: the read returns the limit and clears both the flag and the interrupt. Writing the limit restarts the count. A second address changes the limit without disturbing the running count. A limit of zero selects free-running operation, in which the counter wraps at its top value and never signals a match.

Top module: `limit_timer`

## Requirements
- R1: The word offset is `addr[4:2]`. Offset 0 is the limit, offset 1 is the counter and offset 2 is the limit-without-restart. Read data appears on `rdata` after the clock edge that accepts `req` with `we` low, and holds until the next read.
- R2: Each cycle with `tick_en` high adds one to the count field, bits 30..9. A counter read returns `{reached, count, 9'b0}`, so bits 8..0 are always zero.
- R3: When a tick brings the count equal to a nonzero limit, `reached` and `irq` are both set at that same edge.
- R4: On the tick after the count has reached a nonzero limit, the count becomes zero and counting continues.
- R5: A read of offset 0 returns the limit with bit 31 zero and clears `reached` and `irq`. If a match occurs in the same cycle, the match wins and both stay set.
- R6: A write to offset 0 does four things:
  - it stores `wdata & 32'h7FFFFE00` as the limit;
  - it sets the count to zero, even if a tick arrives in the same cycle;
  - it lowers `irq`;
  - it leaves `reached` unchanged.
- R7: A write to offset 2 stores `wdata & 32'h7FFFFE00` as the limit and leaves the count unchanged.
- R8: With a limit of zero, no tick sets `reached` or `irq`, and the count wraps from `32'h7FFFFE00` to zero.
- R9: Writes to offset 1 and to offsets 3 to 7 have no effect. Reads of offsets 3 to 7 return zero.
- R10: After reset the limit, count, `reached`, `irq` and `rdata` are all zero, and the counter advances on the first tick.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_en | input | 1 | One-cycle count enable |
| req | input | 1 | Bus access strobe |
| we | input | 1 | Write when high, read when low |
| addr | input | 5 | Byte address; bits 4..2 select the word |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| irq | output | 1 | Level interrupt |

## Verification
Every result is due one edge after its cause:
- Read data appears on `rdata` after the edge that accepts the read.
- `irq` and `reached` change at the edge that carries the matching tick, read or write.
- The count restarts at the edge after the match.

The bench drives inputs on falling edges. A scoreboard queue holds the expected read word, and the monitor compares it at the falling edge after the accepting rising edge. Interrupt levels are sampled at that same falling edge, once the driving task returns. Same-cycle collisions (a tick with a limit write, a match with an acknowledge) are driven within a single bus cycle, so their priority is visible in the next sample.

// File: rtl/limit_timer.sv
module limit_timer #(
  parameter int CNT_W  = 22,
  parameter int FRAC_W = 9,
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              req,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  output logic              irq
);
  localparam int OFF_W = ADDR_W - 2;
  localparam logic [OFF_W-1:0] OFF_LIM   = OFF_W'(0);
  localparam logic [OFF_W-1:0] OFF_CNT   = OFF_W'(1);
  localparam logic [OFF_W-1:0] OFF_LIMNR = OFF_W'(2);

  logic [CNT_W-1:0] lim, cnt;
  logic             reached;

  wire [OFF_W-1:0] off    = addr[ADDR_W-1:2];
  wire             rd     = req & ~we;
  wire             wr     = req & we;
  wire             wr_lim = wr & (off == OFF_LIM);
  wire             wr_nr  = wr & (off == OFF_LIMNR);
  wire             rd_lim = rd & (off == OFF_LIM);
  wire [CNT_W-1:0] new_lim = wdata[FRAC_W +: CNT_W];
  wire [CNT_W-1:0] cnt_inc = cnt + 1'b1;
  wire             lim_on  = (lim != '0);
  wire             at_lim  = lim_on & (cnt == lim);
  wire             arrive  = tick_en & lim_on & (cnt_inc == lim) & ~wr_lim;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lim <= '0;
    end else if (wr_lim | wr_nr) begin
      lim <= new_lim;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (wr_lim) begin
      cnt <= '0;
    end else if (tick_en) begin
      cnt <= at_lim ? '0 : cnt_inc;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reached <= 1'b0;
      irq     <= 1'b0;
    end else begin
      if (arrive)      reached <= 1'b1;
      else if (rd_lim) reached <= 1'b0;
      if (arrive)                irq <= 1'b1;
      else if (rd_lim | wr_lim)  irq <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata <= '0;
    end else if (rd) begin
      case (off)
        OFF_LIM: rdata <= {1'b0, lim, {FRAC_W{1'b0}}};
        OFF_CNT: rdata <= {reached, cnt, {FRAC_W{1'b0}}};
        default: rdata <= '0;
      endcase
    end
  end

  p_low_bits_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rd |=> rdata[FRAC_W-1:0] == '0);

  p_flag_needs_limit_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(reached) |-> $past(lim) != '0);

  p_match_sets_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_en && lim != '0 && cnt_inc == lim && !wr_lim) |=> (irq && reached));

  p_restart_after_match_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_en && at_lim && !wr_lim) |=> cnt == '0);

  p_ack_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_lim && !tick_en) |=> (!irq && !reached));

  p_write_restarts_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_lim |=> (cnt == '0 && !irq && lim == $past(new_lim)));

  p_keep_count_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_nr && !tick_en) |=> $stable(cnt));
endmodule

// File: tb/test_limit_timer.sv
module test_limit_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_en = 1'b0, req = 1'b0, we = 1'b0;
  logic [4:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic        pend = 1'b0;

  always #10 clk = ~clk;

  limit_timer i_limit_timer (.clk(clk), .rst_n(rst_n), .tick_en(tick_en), .req(req),
    .we(we), .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq));

  always @(posedge clk) pend <= req & ~we;

  always @(negedge clk) begin
    if (pend && exp_q.size() > 0) begin
      logic [31:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (rdata !== e) begin
        fails++;
        $display("FAIL %s rdata actual %h expected %h", t, rdata, e);
      end
    end
  end

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      tick_en = 1'b1;
      @(negedge clk);
    end
    tick_en = 1'b0;
  endtask

  task automatic do_write(input logic [4:0] a, input logic [31:0] d, input logic tk);
    req = 1'b1; we = 1'b1; addr = a; wdata = d; tick_en = tk;
    @(negedge clk);
    req = 1'b0; we = 1'b0; tick_en = 1'b0;
  endtask

  task automatic do_read(input logic [4:0] a, input logic [31:0] e, input logic tk, input string t);
    exp_q.push_back(e);
    tag_q.push_back(t);
    req = 1'b1; we = 1'b0; addr = a; tick_en = tk;
    @(negedge clk);
    req = 1'b0; tick_en = 1'b0;
  endtask

  task automatic chk_irq(input logic e, input string t);
    checks++;
    if (irq !== e) begin
      fails++;
      $display("FAIL %s irq actual %b expected %b", t, irq, e);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    checks++;
    if (rdata !== 32'h0) begin
      fails++;
      $display("FAIL R10 rdata actual %h expected %h", rdata, 32'h0);
    end
    chk_irq(1'b0, "R10");
    do_read(5'h04, 32'h0, 1'b0, "R10 count");
    do_read(5'h00, 32'h0, 1'b0, "R10 limit");

    tick(5);
    do_read(5'h04, 32'h0000_0A00, 1'b0, "R2 free count");

    do_write(5'h00, 32'h8000_0DFF, 1'b0);
    do_read(5'h00, 32'h0000_0C00, 1'b0, "R6 masked limit");
    do_read(5'h04, 32'h0, 1'b0, "R6 restart");

    tick(5);
    chk_irq(1'b0, "R3 before match");
    do_read(5'h04, 32'h0000_0A00, 1'b0, "R2 count 5");
    tick(1);
    chk_irq(1'b1, "R3 match irq");
    do_read(5'h04, 32'h8000_0C00, 1'b0, "R3 reached bit");
    tick(1);
    do_read(5'h04, 32'h8000_0000, 1'b0, "R4 back to zero");
    chk_irq(1'b1, "R4 irq held");

    do_read(5'h00, 32'h0000_0C00, 1'b0, "R5 ack read");
    chk_irq(1'b0, "R5 ack irq");
    do_read(5'h04, 32'h0, 1'b0, "R5 flag cleared");

    do_write(5'h04, 32'h1234_5600, 1'b0);
    do_write(5'h0C, 32'hFFFF_FFFF, 1'b0);
    do_read(5'h04, 32'h0, 1'b0, "R9 counter write ignored");
    do_read(5'h00, 32'h0000_0C00, 1'b0, "R9 limit untouched");

    tick(3);
    do_write(5'h08, 32'h0000_11FF, 1'b0);
    do_read(5'h04, 32'h0000_0600, 1'b0, "R7 count kept");
    do_read(5'h00, 32'h0000_1000, 1'b0, "R7 new limit");
    tick(5);
    chk_irq(1'b1, "R7 match at new limit");
    do_read(5'h04, 32'h8000_1000, 1'b0, "R7 reached at 8");

    do_write(5'h00, 32'h0, 1'b0);
    chk_irq(1'b0, "R6 write lowers irq");
    do_read(5'h04, 32'h8000_0000, 1'b0, "R6 flag kept");
    do_read(5'h00, 32'h0, 1'b0, "R8 zero limit");
    tick(20);
    chk_irq(1'b0, "R8 free-run no irq");
    do_read(5'h04, 32'h0000_2800, 1'b0, "R8 free-run count");

    do_write(5'h00, 32'h0, 1'b1);
    do_read(5'h04, 32'h0, 1'b0, "R6 write beats tick");

    do_read(5'h0C, 32'h0, 1'b0, "R9 offset 3");
    do_read(5'h10, 32'h0, 1'b0, "R9 offset 4");
    do_read(5'h14, 32'h0, 1'b0, "R1 offset 5");
    do_read(5'h1C, 32'h0, 1'b0, "R1 offset 7");

    do_write(5'h00, 32'h0000_0400, 1'b0);
    tick(1);
    do_read(5'h00, 32'h0000_0400, 1'b1, "R5 collide read");
    chk_irq(1'b1, "R5 match wins");
    do_read(5'h04, 32'h8000_0400, 1'b0, "R5 match wins flag");

    repeat (2) @(negedge clk);
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule